// File: doc/BRIEF.md
# Cycle-Steal DMA Engine

A four-channel DMA engine that moves one data unit (a byte or a 16-bit halfword) per accepted request and then releases the bus. Each channel holds a 24-bit source address, a 24-bit destination address, a 16-bit transfer counter, and a reload value. It also has a control word that sets the operating mode, the unit size, which side of the transfer stays fixed, and which peripheral request line the channel listens to. Channels are set up through a narrow write port. That same port also carries a per-channel software trigger.

When a channel has a pending request, the engine raises a bus request. It waits for a grant, reads one unit from the source and writes it to the destination. After that it updates the counter and the stepping address. The memory side is a simple synchronous master: read data is valid in the cycle after the read strobe. A one-cycle interrupt pulse marks the end of a channel's count. In repeat mode the channel then re-arms itself from its reload value.

Top module: `dma_steal_engine`

## Requirements
- R1: When several channels are pending at grant time, the lowest-numbered channel is served first. Channel 0 has the highest priority and channel 3 the lowest.
- R2: Each accepted request moves exactly one unit. `mem_re` is high for one cycle. `mem_we` is high for one cycle, two cycles after `mem_re`. `bus_req` drops when the write completes.
- R3: Control bit 2 selects the unit size (1 = 16 bits, 0 = 8 bits). A 16-bit unit uses the whole data bus and steps the moving address by 2. An 8-bit unit carries the byte in the low eight data bits and steps by 1.
- R4: Control bit 3 chooses the fixed side. With the bit at 0, the source steps forward and the destination stays fixed. With the bit at 1, the source stays fixed and the destination steps forward.
- R5: Control bits [1:0] hold the mode: 01 is single, 11 is repeat, and 00 or 10 disables the channel. Only a channel with mode 01 or 11 and a nonzero counter accepts requests.
- R6: In single mode the counter drops by one per unit. Once it reaches zero, further requests move nothing.
- R7: In repeat mode, the unit that takes the counter from 1 to 0 instead reloads the counter from the reload value and puts the moving address back to the last value written for it. This only happens when the reload value is nonzero.
- R8: `irq[c]` pulses for exactly one cycle, in the cycle after the write of the unit that took channel c's counter from 1 to 0. It pulses at no other time.
- R9: A request is either the rising edge of the peripheral line chosen by control bits [4+:3], or a trigger write. Either one sets a pending bit, and the grant clears that bit. An edge that arrives in the same cycle as the clear leaves the bit set. A line held high produces only one request. Requests to a channel that is not armed are dropped.
- R10: No read or write is issued until `bus_gnt` is seen high while `bus_req` is high.
- R11: A configuration write with `cfg_field` selects the target: 0 is source, 1 is destination, 2 is counter, 3 is reload, 4 is control and 5 is trigger. It applies to channel `cfg_chan` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_chan | input | 2 | Channel addressed by the write |
| cfg_field | input | 3 | Register selector (R11) |
| cfg_wdata | input | 24 | Write data |
| req_lines | input | 8 | Peripheral request lines |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| mem_addr | output | 24 | Byte address of the current access |
| mem_re | output | 1 | Read strobe |
| mem_we | output | 1 | Write strobe |
| mem_wide | output | 1 | 1 = 16-bit access, 0 = byte access |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after `mem_re` |
| irq | output | 4 | Per-channel count-end pulse |

## Verification
Two events can land on the same clock edge: the grant that clears a channel's pending bit, and a fresh rising edge on that channel's peripheral line that sets the bit again. The bench provokes this by holding the grant low while a software-triggered request waits. It then raises the grant and the selected line at the same falling edge. The result is judged by counting write strobes. The count must be two, not one. Holding the line high afterwards must add nothing, and a later new edge must add exactly one unit.

// File: rtl/dma_steal_pkg.sv
package dma_steal_pkg;
  typedef enum logic [2:0] {
    FLD_SRC  = 3'd0,
    FLD_DST  = 3'd1,
    FLD_CNT  = 3'd2,
    FLD_RLD  = 3'd3,
    FLD_CTRL = 3'd4,
    FLD_TRIG = 3'd5
  } fld_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ARB, ST_RD, ST_CAP, ST_WR
  } st_e;

  localparam logic [1:0] MODE_RPT = 2'b11;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_steal_pkg::*;
#(
  parameter int AW  = 24,
  parameter int CW  = 16,
  parameter int RSW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  fld_e           wr_fld,
  input  logic [AW-1:0]  wr_data,
  input  logic           step,
  output logic [AW-1:0]  src_addr,
  output logic [AW-1:0]  dst_addr,
  output logic [CW-1:0]  count,
  output logic           wide,
  output logic [RSW-1:0] rsel,
  output logic           armed
);
  logic [AW-1:0] src_base, dst_base;
  logic [CW-1:0] reload;
  logic [1:0]    mode;
  logic          src_fix;
  logic [AW-1:0] inc;
  logic          wrap;

  assign inc   = {{(AW-2){1'b0}}, wide, ~wide};
  assign armed = mode[0] && (count != '0);
  assign wrap  = (count == CW'(1)) && (mode == MODE_RPT) && (reload != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      src_addr <= '0; dst_addr <= '0; src_base <= '0; dst_base <= '0;
      count <= '0; reload <= '0; mode <= '0; wide <= 1'b0;
      src_fix <= 1'b0; rsel <= '0;
    end else if (wr_en) begin
      case (wr_fld)
        FLD_SRC:  begin src_addr <= wr_data; src_base <= wr_data; end
        FLD_DST:  begin dst_addr <= wr_data; dst_base <= wr_data; end
        FLD_CNT:  count  <= wr_data[CW-1:0];
        FLD_RLD:  reload <= wr_data[CW-1:0];
        FLD_CTRL: begin
          mode    <= wr_data[1:0];
          wide    <= wr_data[2];
          src_fix <= wr_data[3];
          rsel    <= wr_data[4 +: RSW];
        end
        default: ;
      endcase
    end else if (step && count != '0) begin
      if (wrap) begin
        count <= reload;
        if (src_fix) dst_addr <= dst_base;
        else         src_addr <= src_base;
      end else begin
        count <= count - CW'(1);
        if (src_fix) dst_addr <= dst_addr + inc;
        else         src_addr <= src_addr + inc;
      end
    end
  end
endmodule

// File: rtl/dma_req_capture.sv
module dma_req_capture #(
  parameter int NCH  = 4,
  parameter int NREQ = 8,
  parameter int RSW  = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NREQ-1:0]          lines,
  input  logic [NCH-1:0][RSW-1:0]  rsel,
  input  logic [NCH-1:0]           sw,
  input  logic [NCH-1:0]           armed,
  input  logic [NCH-1:0]           clr,
  output logic [NCH-1:0]           pend
);
  logic [NREQ-1:0] prev;
  logic [NREQ-1:0] rise;

  assign rise = lines & ~prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= lines;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    assign hit = (rise[rsel[c]] | sw[c]) & armed[c];
    always_ff @(posedge clk) begin
      if (rst) pend[c] <= 1'b0;
      else     pend[c] <= hit | (pend[c] & ~clr[c] & armed[c]);
    end
  end
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int NCH = 4,
  parameter int CHW = 2
) (
  input  logic [NCH-1:0] req,
  output logic           any,
  output logic [CHW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = CHW'(i);
      end
    end
  end
endmodule

// File: rtl/dma_steal_engine.sv
module dma_steal_engine
  import dma_steal_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int NREQ = 8,
  parameter int AW   = 24,
  parameter int DW   = 16,
  parameter int CW   = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_we,
  input  logic [$clog2(NCH)-1:0]  cfg_chan,
  input  logic [2:0]              cfg_field,
  input  logic [AW-1:0]           cfg_wdata,
  input  logic [NREQ-1:0]         req_lines,
  output logic                    bus_req,
  input  logic                    bus_gnt,
  output logic [AW-1:0]           mem_addr,
  output logic                    mem_re,
  output logic                    mem_we,
  output logic                    mem_wide,
  output logic [DW-1:0]           mem_wdata,
  input  logic [DW-1:0]           mem_rdata,
  output logic [NCH-1:0]          irq
);
  localparam int CHW = $clog2(NCH);
  localparam int RSW = $clog2(NREQ);
  localparam int HW  = DW / 2;

  st_e                     st;
  logic [CHW-1:0]          cur;
  logic [AW-1:0]           src_a [NCH];
  logic [AW-1:0]           dst_a [NCH];
  logic [CW-1:0]           cnt_a [NCH];
  logic [NCH-1:0]          wide_v, armed_v, sw_v, clr_v, step_v, pend_v, elig;
  logic [NCH-1:0][RSW-1:0] rsel_v;
  logic                    any;
  logic [CHW-1:0]          win;
  fld_e                    fld;

  assign fld  = fld_e'(cfg_field);
  assign elig = pend_v & armed_v;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic sel;
    assign sel       = cfg_we && (cfg_chan == CHW'(c));
    assign sw_v[c]   = sel && (fld == FLD_TRIG);
    assign clr_v[c]  = (st == ST_ARB) && bus_gnt && any && (win == CHW'(c));
    assign step_v[c] = (st == ST_WR) && (cur == CHW'(c));

    dma_chan_regs #(.AW(AW), .CW(CW), .RSW(RSW)) u_regs (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (sel && (fld != FLD_TRIG)),
      .wr_fld   (fld),
      .wr_data  (cfg_wdata),
      .step     (step_v[c]),
      .src_addr (src_a[c]),
      .dst_addr (dst_a[c]),
      .count    (cnt_a[c]),
      .wide     (wide_v[c]),
      .rsel     (rsel_v[c]),
      .armed    (armed_v[c])
    );
  end

  dma_req_capture #(.NCH(NCH), .NREQ(NREQ), .RSW(RSW)) u_cap (
    .clk   (clk),
    .rst   (rst),
    .lines (req_lines),
    .rsel  (rsel_v),
    .sw    (sw_v),
    .armed (armed_v),
    .clr   (clr_v),
    .pend  (pend_v)
  );

  dma_prio_pick #(.NCH(NCH), .CHW(CHW)) u_pick (
    .req (elig),
    .any (any),
    .idx (win)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; cur <= '0; bus_req <= 1'b0;
      mem_re <= 1'b0; mem_we <= 1'b0; mem_wide <= 1'b0;
      mem_addr <= '0; mem_wdata <= '0; irq <= '0;
    end else begin
      irq <= '0;
      case (st)
        ST_IDLE: if (any) begin
          bus_req <= 1'b1;
          st      <= ST_ARB;
        end
        ST_ARB: if (!any) begin
          bus_req <= 1'b0;
          st      <= ST_IDLE;
        end else if (bus_gnt) begin
          cur      <= win;
          mem_re   <= 1'b1;
          mem_addr <= src_a[win];
          mem_wide <= wide_v[win];
          st       <= ST_RD;
        end
        ST_RD: begin
          mem_re <= 1'b0;
          st     <= ST_CAP;
        end
        ST_CAP: begin
          mem_we    <= 1'b1;
          mem_addr  <= dst_a[cur];
          mem_wdata <= mem_wide ? mem_rdata : {{HW{1'b0}}, mem_rdata[HW-1:0]};
          st        <= ST_WR;
        end
        ST_WR: begin
          mem_we   <= 1'b0;
          bus_req  <= 1'b0;
          irq[cur] <= (cnt_a[cur] == CW'(1));
          st       <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_steal_checker.sv
module dma_steal_checker #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           bus_req,
  input logic           bus_gnt,
  input logic           mem_re,
  input logic           mem_we,
  input logic [NCH-1:0] irq
);
  AST_RE_SINGLE: assert property (@(posedge clk) disable iff (rst) mem_re |=> !mem_re); // R2
  AST_WE_FOLLOWS_RE: assert property (@(posedge clk) disable iff (rst) mem_re |=> ##1 mem_we); // R2
  AST_RE_WE_EXCL: assert property (@(posedge clk) disable iff (rst) !(mem_re && mem_we)); // R2
  AST_ACCESS_HOLDS_BUS: assert property (@(posedge clk) disable iff (rst) (mem_re || mem_we) |-> bus_req); // R10
  AST_READ_AFTER_GNT: assert property (@(posedge clk) disable iff (rst) $rose(mem_re) |-> $past(bus_gnt) && $past(bus_req)); // R10
  AST_IRQ_ONE_CHAN: assert property (@(posedge clk) disable iff (rst) $onehot0(irq)); // R8
  AST_IRQ_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst) (|irq) |-> $past(mem_we)); // R8
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst) (|irq) |=> (irq == '0)); // R8
endmodule

bind dma_steal_engine dma_steal_checker #(.NCH(NCH)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .bus_req (bus_req),
  .bus_gnt (bus_gnt),
  .mem_re  (mem_re),
  .mem_we  (mem_we),
  .irq     (irq)
);

// File: tb/test_dma_steal_engine.sv
module test_dma_steal_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_chan = '0;
  logic [2:0]  cfg_field = '0;
  logic [23:0] cfg_wdata = '0;
  logic [7:0]  req_lines = '0;
  logic        bus_gnt = 1'b1;
  logic        bus_req, mem_re, mem_we, mem_wide;
  logic [23:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] rdq = '0;
  logic [3:0]  irq;

  int n_chk = 0, n_bad = 0;
  int wr_cnt = 0, re_cnt = 0, ord_n = 0;
  int irq_cnt [4] = '{0, 0, 0, 0};
  int ord [32];
  logic [7:0] wmem [256];

  always #5 clk = ~clk;

  dma_steal_engine i_dma_steal_engine (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_chan(cfg_chan),
    .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .req_lines(req_lines),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_addr(mem_addr),
    .mem_re(mem_re), .mem_we(mem_we), .mem_wide(mem_wide),
    .mem_wdata(mem_wdata), .mem_rdata(rdq), .irq(irq)
  );

  function automatic logic [7:0] pat(input logic [8:0] a);
    return a[7:0] ^ 8'hA5;
  endfunction

  function automatic logic [7:0] rd_byte(input logic [8:0] a);
    return a[8] ? wmem[a[7:0]] : pat(a);
  endfunction

  always @(posedge clk) begin
    if (mem_we) begin
      wmem[mem_addr[7:0]] <= mem_wdata[7:0];
      if (mem_wide) wmem[mem_addr[7:0] + 8'd1] <= mem_wdata[15:8];
      wr_cnt <= wr_cnt + 1;
    end
    if (mem_re) begin
      rdq    <= {rd_byte(mem_addr[8:0] + 9'd1), rd_byte(mem_addr[8:0])};
      re_cnt <= re_cnt + 1;
    end
    for (int c = 0; c < 4; c++) begin
      if (irq[c]) begin
        irq_cnt[c] <= irq_cnt[c] + 1;
        ord[ord_n] <= c;
        ord_n      <= ord_n + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] ch, input logic [2:0] f, input logic [23:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_chan = ch; cfg_field = f; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic prog(input logic [1:0] ch, input logic [23:0] s, input logic [23:0] d,
                      input logic [15:0] n, input logic [15:0] r, input logic [23:0] ctl);
    cfg(ch, 3'd0, s); cfg(ch, 3'd1, d); cfg(ch, 3'd2, {8'h0, n});
    cfg(ch, 3'd3, {8'h0, r}); cfg(ch, 3'd4, ctl);
  endtask

  task automatic trig(input logic [1:0] ch);
    cfg(ch, 3'd5, 24'h0);
    repeat (10) @(negedge clk);
  endtask

  // ch(2) wide(1) srcfix(1) src(12) dst(12) units(4)
  localparam logic [31:0] VEC [4] = '{
    {2'd0, 1'b0, 1'b0, 12'h010, 12'h100, 4'd3},
    {2'd1, 1'b1, 1'b0, 12'h020, 12'h110, 4'd2},
    {2'd2, 1'b0, 1'b1, 12'h030, 12'h120, 4'd3},
    {2'd3, 1'b1, 1'b1, 12'h040, 12'h130, 4'd2}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int w0, i0, r0, o0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!bus_req && !mem_re && !mem_we && irq == 4'h0, "R2 reset idle", {bus_req, mem_re, mem_we, irq}, 0);

    // Vector table: single mode, each unit size and fixed side (R3 R4 R6 R8 R11)
    for (int v = 0; v < 4; v++) begin
      logic [1:0] ch; logic wd, sf; logic [8:0] s, d; int n, b;
      ch = VEC[v][31:30]; wd = VEC[v][29]; sf = VEC[v][28];
      s = VEC[v][24:16]; d = VEC[v][12:4]; n = int'(VEC[v][3:0]);
      b = wd ? 2 : 1;
      prog(ch, {15'h0, s}, {15'h0, d}, 16'(n), 16'h0, {20'h0, sf, wd, 2'b01});
      w0 = wr_cnt; i0 = irq_cnt[ch];
      for (int k = 0; k < n; k++) trig(ch);
      chk(wr_cnt - w0 == n, "R2 one unit per request", wr_cnt - w0, n);
      chk(irq_cnt[ch] - i0 == 1, "R8 irq on count end", irq_cnt[ch] - i0, 1);
      if (!sf) begin
        for (int j = 0; j < b; j++)
          chk(wmem[d[7:0] + 8'(j)] == pat(s + 9'((n - 1) * b + j)), "R4 R3 fixed dest gets last unit",
              wmem[d[7:0] + 8'(j)], pat(s + 9'((n - 1) * b + j)));
      end else begin
        for (int k = 0; k < n; k++)
          for (int j = 0; j < b; j++)
            chk(wmem[d[7:0] + 8'(k * b + j)] == pat(s + 9'(j)), "R4 R3 dest steps, source fixed",
                wmem[d[7:0] + 8'(k * b + j)], pat(s + 9'(j)));
      end
      w0 = wr_cnt;
      trig(ch);
      chk(wr_cnt == w0 && !bus_req, "R6 zero count ignores request", wr_cnt - w0, 0);
    end

    // R1 priority, R10 grant hold-off
    for (int c = 0; c < 4; c++)
      prog(2'(c), 24'h060 + 24'(c), 24'h150 + 24'(c), 16'd1, 16'd0, 24'h1);
    @(negedge clk); bus_gnt = 1'b0;
    r0 = re_cnt; o0 = ord_n;
    cfg(2'd3, 3'd5, 0); cfg(2'd2, 3'd5, 0); cfg(2'd1, 3'd5, 0); cfg(2'd0, 3'd5, 0);
    repeat (6) @(negedge clk);
    chk(bus_req && re_cnt == r0, "R10 no access without grant", {bus_req, 8'(re_cnt - r0)}, 9'h100);
    bus_gnt = 1'b1;
    repeat (40) @(negedge clk);
    chk(ord_n - o0 == 4, "R1 all four served", ord_n - o0, 4);
    for (int k = 0; k < 4; k++)
      chk(ord[o0 + k] == k, "R1 fixed priority order", ord[o0 + k], k);

    // R7 repeat mode reload and address restore
    prog(2'd0, 24'h050, 24'h140, 16'd2, 16'd2, 24'h3);
    w0 = wr_cnt; i0 = irq_cnt[0];
    trig(2'd0); trig(2'd0); trig(2'd0);
    chk(wr_cnt - w0 == 3, "R7 repeat keeps running", wr_cnt - w0, 3);
    chk(irq_cnt[0] - i0 == 1, "R8 R7 single irq at wrap", irq_cnt[0] - i0, 1);
    chk(wmem[8'h40] == pat(9'h050), "R7 source restored after reload", wmem[8'h40], pat(9'h050));

    // R5 disabled modes 00 and 10
    prog(2'd2, 24'h070, 24'h170, 16'd4, 16'd0, 24'h0);
    prog(2'd3, 24'h070, 24'h171, 16'd4, 16'd0, 24'h2);
    w0 = wr_cnt;
    trig(2'd2); trig(2'd3);
    chk(wr_cnt == w0 && !bus_req, "R5 disabled channel idle", wr_cnt - w0, 0);

    // R9 edge capture and same-cycle set/clear
    prog(2'd1, 24'h078, 24'h180, 16'd3, 16'd0, {17'h0, 3'd2, 4'b0001});
    w0 = wr_cnt; i0 = irq_cnt[1];
    @(negedge clk); bus_gnt = 1'b0;
    cfg(2'd1, 3'd5, 0);
    repeat (3) @(negedge clk);
    bus_gnt = 1'b1; req_lines[2] = 1'b1;
    repeat (20) @(negedge clk);
    chk(wr_cnt - w0 == 2, "R9 edge at clear stays pending", wr_cnt - w0, 2);
    repeat (20) @(negedge clk);
    chk(wr_cnt - w0 == 2, "R9 held line no retrigger", wr_cnt - w0, 2);
    req_lines[2] = 1'b0;
    repeat (3) @(negedge clk);
    req_lines[2] = 1'b1;
    repeat (15) @(negedge clk);
    chk(wr_cnt - w0 == 3, "R9 new edge one unit", wr_cnt - w0, 3);
    chk(irq_cnt[1] - i0 == 1, "R8 irq after third unit", irq_cnt[1] - i0, 1);
    chk(wmem[8'h80] == pat(9'h07A), "R3 byte unit steps by one", wmem[8'h80], pat(9'h07A));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule